// File: doc/BRIEF.md
# Dadda Tree Unsigned Multiplier

This block multiplies two unsigned N-bit integers and returns the full 2N-bit product. The product comes from three sections of combinational logic. First, every pairing of one bit of each operand is ANDed, which gives the partial-product bits. Second, those bits are compressed by a fixed sequence of full-adder and half-adder stages. Third, one carry-propagate adder sums the last two rows. A single output register, reset synchronously, sits after the adder so that the block can be timed as one pipeline stage.

The compression works on columns of equal binary weight. The stages use a falling sequence of height ceilings, built from 2 upward as floor(1.5·d) and applied from the largest value that is still below N down to 2. Each stage places only the adders needed to bring every column down to its ceiling, and it prefers a half adder whenever one bit of reduction is enough. All of the wiring is derived from N when the design is elaborated.

Top module: `dadda_mult`

## Requirements
- R1: `p_o` equals the unsigned product `a_i * b_i`, 2N bits wide, one clock edge after the operands are sampled, for every operand pair.
- R2: While `rst_i` is high at a rising edge, `p_o` becomes all zeros at that edge, whatever the operands are.
- R3: When either operand is zero, `p_o` is zero after the next edge.
- R4: All-ones times all-ones produces (2^N-1)^2, which has the top product bit set and bit 0 set. For N=8 this is 16'hFE01.
- R5: When one operand equals 1, `p_o` equals the other operand, zero-extended to 2N bits.
- R6: When one operand is a power of two 2^j, `p_o` equals the other operand shifted left by j.
- R7: Swapping the two operands gives the same product.
- R8: The reduction ceilings for N=8 are 6, 4, 3 and 2, in that order. A wiring error in any one of these four stages changes at least one product, so the full operand sweep covers every stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the product register updates on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset of the product register |
| a_i | input | N | Multiplicand, unsigned |
| b_i | input | N | Multiplier, unsigned |
| p_o | output | 2N | Registered unsigned product |

## Verification
A misplaced adder, a carry routed to the wrong column, or a bit dropped between stages changes the value of particular columns. It therefore shows up as a wrong `p_o` on the edge right after the operand pairs that drive those columns. The effect is visible within one cycle, but only for some operand values. For this reason the bench sweeps all 65536 pairs at N=8, so that every adder cell in every stage sees every input combination that can reach it. The corner operands (zero, one, powers of two, all-ones) and operand swapping are added to tie failures to specific requirements.

// File: rtl/dadda_pkg.sv
`timescale 1ns/1ps
package dadda_pkg;

    typedef enum logic {CELL_HALF = 1'b0, CELL_FULL = 1'b1} cell_kind_e;

    typedef struct packed {
        logic s;
        logic c;
    } cell_out_t;

    localparam int MAX_COLS = 256;
    localparam int NO_LIMIT = 1 << 30;

    // number of reduction stages: ceilings 2,3,4,6,9,... strictly below n
    function automatic int num_stages(input int n);
        int d;
        int cnt;
        d = 2;
        cnt = 0;
        for (int i = 0; i < 64; i++) begin
            if (d < n) begin
                cnt = cnt + 1;
                d = (d * 3) / 2;
            end
        end
        return cnt;
    endfunction

    // height ceiling applied by stage st (stage 0 uses the largest one)
    function automatic int stage_limit(input int n, input int st);
        int ns;
        int d;
        ns = num_stages(n);
        if (st >= ns) return NO_LIMIT;
        d = 2;
        for (int i = 1; i < ns - st; i++) d = (d * 3) / 2;
        return d;
    endfunction

    // initial partial-product height of column k
    function automatic int pp_height(input int n, input int k);
        if (k > 2 * n - 2) return 0;
        if (k < n) return k + 1;
        return 2 * n - 1 - k;
    endfunction

    // sel: 0 height entering stage s, 1 full adders, 2 half adders, 3 carries in
    function automatic int plan(input int n, input int s, input int k, input int sel);
        int ht [MAX_COLS];
        int lim;
        int cin;
        int ex;
        int nf;
        int nh;
        for (int c = 0; c < MAX_COLS; c++) ht[c] = (c < 2 * n) ? pp_height(n, c) : 0;
        for (int st = 0; st <= s; st++) begin
            lim = stage_limit(n, st);
            cin = 0;
            for (int c = 0; c < 2 * n; c++) begin
                ex = (ht[c] + cin > lim) ? ht[c] + cin - lim : 0;
                nf = ex / 2;
                nh = ex % 2;
                if (st == s && c == k) begin
                    case (sel)
                        0: return ht[c];
                        1: return nf;
                        2: return nh;
                        default: return cin;
                    endcase
                end
                ht[c] = ht[c] + cin - 2 * nf - nh;
                cin = nf + nh;
            end
        end
        return 0;
    endfunction

endpackage

// File: rtl/dadda_cell.sv
`timescale 1ns/1ps
module dadda_cell
    import dadda_pkg::*;
#(
    parameter cell_kind_e KIND = CELL_FULL
) (
    input  logic [2:0] x_i,
    output cell_out_t  y_o
);
    if (KIND == CELL_FULL) begin : g_full
        assign y_o.s = ^x_i;
        assign y_o.c = (x_i[0] & x_i[1]) | (x_i[2] & (x_i[0] | x_i[1]));
    end else begin : g_half
        assign y_o.s = x_i[0] ^ x_i[1];
        assign y_o.c = x_i[0] & x_i[1] & ~x_i[2];
    end
endmodule

// File: rtl/dadda_pp_gen.sv
`timescale 1ns/1ps
module dadda_pp_gen
    import dadda_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]     a_i,
    input  logic [N-1:0]     b_i,
    output logic [2*N*N-1:0] col_o
);
    localparam int W = 2 * N;

    for (genvar k = 0; k < W; k++) begin : g_col
        localparam int LO = (k > N - 1) ? k - N + 1 : 0;
        localparam int HT = pp_height(N, k);
        for (genvar p = 0; p < N; p++) begin : g_bit
            if (p < HT) begin : g_and
                assign col_o[k*N + p] = a_i[LO + p] & b_i[k - LO - p];
            end else begin : g_pad
                assign col_o[k*N + p] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/dadda_stage.sv
`timescale 1ns/1ps
module dadda_stage
    import dadda_pkg::*;
#(
    parameter int N = 8,
    parameter int S = 0
) (
    input  logic [2*N*N-1:0] col_i,
    output logic [2*N*N-1:0] col_o
);
    localparam int W = 2 * N;

    logic [N-1:0] cy [W];

    for (genvar k = 0; k < W; k++) begin : g_col
        localparam int H = plan(N, S, k, 0);
        localparam int F = plan(N, S, k, 1);
        localparam int A = plan(N, S, k, 2);
        localparam int C = plan(N, S, k, 3);
        localparam int U = H - 3 * F - 2 * A;

        cell_out_t    cyo [N];
        logic [N-1:0] cy_in;
        logic [N-1:0] ov;

        for (genvar m = 0; m < N; m++) begin : g_cell
            if (m < F) begin : g_fa
                dadda_cell #(.KIND(CELL_FULL)) u_fa (
                    .x_i(col_i[k*N + 3*m +: 3]),
                    .y_o(cyo[m])
                );
            end else if (m < F + A) begin : g_ha
                dadda_cell #(.KIND(CELL_HALF)) u_ha (
                    .x_i({1'b0, col_i[k*N + 3*F + 2*(m-F) +: 2]}),
                    .y_o(cyo[m])
                );
            end else begin : g_none
                assign cyo[m] = '0;
            end
        end

        always_comb begin
            cy[k] = '0;
            for (int m = 0; m < F + A; m++) cy[k][m] = cyo[m].c;
        end

        if (k == 0) begin : g_cin0
            assign cy_in = '0;
        end else begin : g_cin
            assign cy_in = cy[k-1];
        end

        always_comb begin
            ov = '0;
            for (int m = 0; m < F + A; m++) ov[m] = cyo[m].s;
            for (int m = 0; m < U; m++) ov[F + A + m] = col_i[k*N + 3*F + 2*A + m];
            for (int m = 0; m < C; m++) ov[F + A + U + m] = cy_in[m];
        end

        assign col_o[k*N +: N] = ov;
    end
endmodule

// File: rtl/dadda_cpa.sv
`timescale 1ns/1ps
module dadda_cpa #(
    parameter int N = 8
) (
    input  logic [2*N*N-1:0] col_i,
    output logic [2*N-1:0]   sum_o
);
    localparam int W = 2 * N;

    logic [W-1:0] row_x;
    logic [W-1:0] row_y;

    for (genvar k = 0; k < W; k++) begin : g_row
        assign row_x[k] = col_i[k*N];
        assign row_y[k] = col_i[k*N + 1];
    end

    // carry out of the top column is dropped: the product fits in W bits
    assign sum_o = row_x + row_y;
endmodule

// File: rtl/dadda_mult.sv
`timescale 1ns/1ps
module dadda_mult
    import dadda_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic [N-1:0]   a_i,
    input  logic [N-1:0]   b_i,
    output logic [2*N-1:0] p_o
);
    localparam int W  = 2 * N;
    localparam int NS = num_stages(N);

    logic [W*N-1:0] lvl [NS+1];
    logic [W-1:0]   prod;

    dadda_pp_gen #(.N(N)) u_pp (
        .a_i  (a_i),
        .b_i  (b_i),
        .col_o(lvl[0])
    );

    for (genvar s = 0; s < NS; s++) begin : g_stage
        dadda_stage #(.N(N), .S(s)) u_stage (
            .col_i(lvl[s]),
            .col_o(lvl[s+1])
        );
    end

    dadda_cpa #(.N(N)) u_cpa (
        .col_i(lvl[NS]),
        .sum_o(prod)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) p_o <= '0;
        else       p_o <= prod;
    end
endmodule

// File: rtl/dadda_mult_chk.sv
`timescale 1ns/1ps
module dadda_mult_chk #(
    parameter int N = 8
) (
    input logic           clk_i,
    input logic           rst_i,
    input logic [N-1:0]   a_i,
    input logic [N-1:0]   b_i,
    input logic [2*N-1:0] p_o
);
    localparam int W = 2 * N;
    localparam logic [W-1:0] ONES_SQ = {{(N-1){1'b1}}, 1'b0, {(N-1){1'b0}}, 1'b1};

    a_r1_product: assert property (@(posedge clk_i) disable iff (rst_i)
        !rst_i |=> p_o == (W'($past(a_i)) * W'($past(b_i))));

    a_r2_reset: assert property (@(posedge clk_i)
        rst_i |=> p_o == '0);

    a_r3_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (a_i == '0 || b_i == '0) |=> p_o == '0);

    a_r4_ones: assert property (@(posedge clk_i) disable iff (rst_i)
        (a_i == '1 && b_i == '1) |=> p_o == ONES_SQ);

    a_r5_identity: assert property (@(posedge clk_i) disable iff (rst_i)
        (a_i == N'(1)) |=> p_o == W'($past(b_i)));
endmodule

bind dadda_mult dadda_mult_chk #(.N(N)) chk_i (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .a_i  (a_i),
    .b_i  (b_i),
    .p_o  (p_o)
);

// File: tb/dadda_mult_tb_top.sv
`timescale 1ns/1ps
module dadda_mult_tb_top;
    localparam int N = 8;
    localparam int W = 2 * N;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] a = '0;
    logic [N-1:0] b = '0;
    logic [W-1:0] p;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dadda_mult #(.N(N)) dut_i (
        .clk_i(clk),
        .rst_i(rst),
        .a_i  (a),
        .b_i  (b),
        .p_o  (p)
    );

    task automatic check(input string req, input logic [W-1:0] exp);
        total++;
        if (p !== exp) begin
            bad++;
            $display("FAIL %s: a=%0d b=%0d actual=%0d expected=%0d", req, a, b, p, exp);
        end
    endtask

    task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y);
        @(negedge clk);
        a = x;
        b = y;
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [W-1:0] first;
        // R2: reset holds the product at zero even with all-ones operands
        rst = 1'b1;
        apply('1, '1);
        apply('1, '1);
        check("R2", '0);
        @(negedge clk);
        rst = 1'b0;

        // R1 and R8: every operand pair exercises all four reduction stages
        for (int i = 0; i < (1 << N); i++) begin
            for (int j = 0; j < (1 << N); j++) begin
                apply(N'(i), N'(j));
                check("R1", W'(i * j));
            end
        end

        // R3: a zero operand on either side
        apply('0, 8'hA7);
        check("R3", '0);
        apply(8'h5C, '0);
        check("R3", '0);

        // R4: all ones squared
        apply('1, '1);
        check("R4", 16'hFE01);

        // R5: identity on both sides
        apply(8'd1, 8'hC3);
        check("R5", 16'h00C3);
        apply(8'hFF, 8'd1);
        check("R5", 16'h00FF);

        // R6: powers of two act as shifts
        for (int s = 0; s < N; s++) begin
            apply(8'hB5, N'(1 << s));
            check("R6", W'(16'h00B5 << s));
        end

        // R7: swapped operands give the same product
        apply(8'h9D, 8'h3E);
        first = p;
        apply(8'h3E, 8'h9D);
        check("R7", first);

        // R2: mid-run reset clears a nonzero product
        apply(8'hF0, 8'hF0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R2", '0);
        @(negedge clk);
        rst = 1'b0;
        apply(8'd3, 8'd7);
        check("R1", 16'd21);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule